// File: doc/BRIEF.md
# Timer Interrupt Enable and Pending Register

This block is the interrupt register of a multi-source timer. It holds one enable bit and one pending bit for each of four interrupt sources, named A, B, C and D. The timer logic signals a source condition with a one-cycle pulse on that source's event input, and the pulse sets the matching pending bit. Software reads the whole byte on the read data port. A write to the control register loads the enable nibble and can set pending bits. A write of ones to a separate clear register is the only way to clear pending bits.

A single registered request output tells the interrupt controller that at least one source is both pending and enabled. While the timer is switched off, all pending bits are held at zero and ignore every way of setting them. The enable bits stay writable in that state. If a source event and a clear of the same bit land in the same cycle, the event wins, so no condition is lost.

The reset input asserts asynchronously and is released through a two-stage synchronizer.

Top module: `tmr_irq_reg`

## Requirements
- R1: The read data byte holds the enables for D, C, B and A in bits 7, 6, 5 and 4, and the pending bits for D, C, B and A in bits 3, 2, 1 and 0. Source A is index 0 of `src_evt`, and source D is index 3.
- R2: A pulse on `src_evt[i]` while `tmr_en` is 1 sets pending bit i at the next clock edge.
- R3: A control write (`wr_ctl`) with a 1 in data bit i (i in 0..3) sets pending bit i at the next edge.
- R4: A control write with a 0 in data bit i leaves pending bit i unchanged.
- R5: A clear write (`wr_clr`) with a 1 in data bit i (i in 0..3) clears pending bit i at the next edge. Clear data bits that are 0, and clear data bits 7..4, change nothing.
- R6: When a source event and a clear of the same pending bit occur in the same cycle, the bit ends up set.
- R7: While `tmr_en` is 0, all pending bits become 0 at the next edge, and source events, control writes and clear writes cannot set them. Control writes still load the enable bits.
- R8: `irq` is 1 exactly one cycle after a cycle in which some pending bit and its own enable bit are both 1.
- R9: A control write loads data bits 7..4 into the enable bits at the next edge. A control write that only changes enables does not disturb the pending bits.
- R10: `rst_n` low clears the whole register and `irq` at once. After `rst_n` rises, the register stays in reset for two more clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Timer enable; when 0, pending bits are held clear |
| src_evt | input | 4 | Source event pulses, bit 0 = A … bit 3 = D |
| wr_ctl | input | 1 | Write strobe for the enable/pending register |
| wr_clr | input | 1 | Write strobe for the clear register |
| wdata | input | 8 | Write data for both strobes |
| rdata | output | 8 | Register contents, layout per R1 |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The sequence first builds pending state from single source pulses and then from software sets. This separates the hardware set path from the software set path. Control writes with zeros in the pending field are applied while bits are already set; this tells an ignored zero apart from a write that overwrites the pending bits. A cycle that pulses a source and clears the same bit shows which of the two wins. Switching the timer off while pending bits are set, and while events and writes are also applied, checks the forced clear and shows that the enables stay writable. Enable and pending are raised in different orders, and `irq` is checked at the cycle after each change; this catches a request that is unregistered or that ignores the enables.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  // Next-state decision for one pending bit
  typedef enum logic [1:0] {
    PACT_HOLD = 2'd0,
    PACT_CLR  = 2'd1,
    PACT_SET  = 2'd2,
    PACT_OFF  = 2'd3
  } pend_act_e;

endpackage

// File: rtl/tmr_irq_rst_sync.sv
module tmr_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_irq_pend_slice.sv
module tmr_irq_pend_slice
  import tmr_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_en,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pend_q
);

  pend_act_e act;
  logic      pend_d;

  // Priority: timer off, then any set (hardware or software), then clear
  always_comb begin
    if (!tmr_en) begin
      act = PACT_OFF;
    end else if (hw_set || sw_set) begin
      act = PACT_SET;
    end else if (sw_clr) begin
      act = PACT_CLR;
    end else begin
      act = PACT_HOLD;
    end
  end

  always_comb begin
    unique case (act)
      PACT_OFF:  pend_d = 1'b0;
      PACT_SET:  pend_d = 1'b1;
      PACT_CLR:  pend_d = 1'b0;
      default:   pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/tmr_irq_req.sv
module tmr_irq_req #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] pend_q,
  output logic            irq_q
);

  logic irq_d;

  always_comb begin
    irq_d = |(en_q & pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/tmr_irq_reg.sv
module tmr_irq_reg #(
  parameter int NSRC       = 4,
  parameter int RST_STAGES = 2,
  localparam int REG_W     = 2 * NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             wr_ctl,
  input  logic             wr_clr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);

  logic            rst_int_n;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;
  logic            en_ce;
  logic [NSRC-1:0] pend_q;

  tmr_irq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Enable nibble: loaded by control writes regardless of timer state
  always_comb begin
    en_ce = wr_ctl;
    en_d  = wdata[REG_W-1:NSRC];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_pend
    tmr_irq_pend_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .tmr_en (tmr_en),
      .hw_set (src_evt[g]),
      .sw_set (wr_ctl & wdata[g]),
      .sw_clr (wr_clr & wdata[g]),
      .pend_q (pend_q[g])
    );
  end

  tmr_irq_req #(.NSRC(NSRC)) u_req (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_q   (en_q),
    .pend_q (pend_q),
    .irq_q  (irq)
  );

  assign rdata = {en_q, pend_q};

endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int NSRC       = 4,
  localparam int REG_W     = 2 * NSRC
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             tmr_en,
  input logic [NSRC-1:0]  src_evt,
  input logic             wr_ctl,
  input logic             wr_clr,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic             irq
);

  logic [NSRC-1:0] pend_v;
  logic [NSRC-1:0] en_v;
  assign pend_v = rdata[NSRC-1:0];
  assign en_v   = rdata[REG_W-1:NSRC];

  p_hw_set_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tmr_en && |src_evt) |=> ((pend_v & $past(src_evt)) == $past(src_evt)));

  p_no_fall_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tmr_en && !wr_clr) |=> ((pend_v & $past(pend_v)) == $past(pend_v)));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tmr_en && wr_clr && |(src_evt & wdata[NSRC-1:0]))
      |=> ((pend_v & $past(src_evt & wdata[NSRC-1:0])) == $past(src_evt & wdata[NSRC-1:0])));

  p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tmr_en |=> (pend_v == '0));

  p_irq_late_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (irq == |($past(en_v) & $past(pend_v))));

  p_en_load_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_ctl |=> (en_v == $past(wdata[REG_W-1:NSRC])));

endmodule

bind tmr_irq_reg tmr_irq_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .tmr_en    (tmr_en),
  .src_evt   (src_evt),
  .wr_ctl    (wr_ctl),
  .wr_clr    (wr_clr),
  .wdata     (wdata),
  .rdata     (rdata),
  .irq       (irq)
);

// File: tb/tb_tmr_irq_reg.sv
`timescale 1ns/1ps
module tb_tmr_irq_reg;

  localparam int NSRC = 4;
  localparam int W    = 2 * NSRC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tmr_en;
  logic [NSRC-1:0] src_evt;
  logic          wr_ctl;
  logic          wr_clr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic          irq;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [W-1:0] exp_rd;
    logic         exp_irq;
    string        tag;
  } exp_t;

  exp_t      sb_q[$];
  logic [W-1:0] mdl;

  always #10 clk = ~clk;

  tmr_irq_reg dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_en  (tmr_en),
    .src_evt (src_evt),
    .wr_ctl  (wr_ctl),
    .wr_clr  (wr_clr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq)
  );

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic en, input logic [NSRC-1:0] evt,
                      input logic wc, input logic wcl, input logic [W-1:0] wd,
                      input string tag);
    exp_t e;
    logic [NSRC-1:0] p, en_n;
    @(negedge clk);
    tmr_en = en; src_evt = evt; wr_ctl = wc; wr_clr = wcl; wdata = wd;
    e.exp_irq = |(mdl[W-1:NSRC] & mdl[NSRC-1:0]);
    p    = mdl[NSRC-1:0];
    en_n = mdl[W-1:NSRC];
    if (wc) en_n = wd[W-1:NSRC];
    if (!en) p = '0;
    else begin
      if (wcl) p = p & ~wd[NSRC-1:0];
      p = p | evt;
      if (wc) p = p | wd[NSRC-1:0];
    end
    mdl = {en_n, p};
    e.exp_rd = mdl;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tmr_en, '0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] rd, input logic ir);
    n_vec++;
    if (rdata !== rd || irq !== ir) begin
      n_fail++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rdata, irq, rd, ir);
    end
  endtask

  // Monitor: compares shortly after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, e.exp_rd, e.exp_irq);
      end
    end
  end

  initial begin
    rst_n = 1'b0; tmr_en = 1'b0; src_evt = '0; wr_ctl = 1'b0; wr_clr = 1'b0; wdata = '0;
    mdl = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", 8'h00, 1'b0);
    rst_n = 1'b1;
    // R10: held in reset for two edges after release; a write here is lost
    tmr_en = 1'b1; wr_ctl = 1'b1; wdata = 8'hFF;
    @(posedge clk); #5;
    chk("R10 sync hold", 8'h00, 1'b0);
    @(negedge clk);
    wr_ctl = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R10 after release", 8'h00, 1'b0);

    step(1, 4'h0, 1, 0, 8'hF0, "R9 R1 load enables");
    step(1, 4'h1, 0, 0, 8'h00, "R2 R1 event A");
    idle("R8 irq after A");
    step(1, 4'h4, 0, 0, 8'h00, "R2 event C");
    step(1, 4'h0, 1, 0, 8'hF0, "R4 zero write keeps pending");
    step(1, 4'h0, 0, 1, 8'hF1, "R5 clear A only");
    step(1, 4'h0, 1, 0, 8'h0A, "R3 sw set B D, enables off");
    idle("R8 irq drops with enables off");
    step(1, 4'h2, 0, 1, 8'h02, "R6 set wins over clear on B");
    step(1, 4'h0, 0, 1, 8'h0F, "R5 clear all");
    idle("R5 idle after clear");
    step(1, 4'h0, 1, 0, 8'h3F, "R3 sw set all");
    step(0, 4'hF, 1, 0, 8'h3F, "R7 timer off clears, enables load");
    step(0, 4'hF, 0, 0, 8'h00, "R7 events ignored while off");
    step(1, 4'h8, 0, 0, 8'h00, "R2 event D, D disabled");
    idle("R8 no irq with D disabled");
    step(1, 4'h0, 1, 0, 8'h80, "R9 enable D, pending kept");
    idle("R8 irq one cycle after enable");
    idle("R8 irq held");
    step(0, 4'h0, 0, 0, 8'h00, "R7 disable with pending");
    step(1, 4'h0, 0, 0, 8'h00, "R8 irq falls");
    idle("R8 idle");
    step(1, 4'h0, 1, 0, 8'h11, "R3 set A with enable A");
    idle("R8 irq from A");
    repeat (2) @(negedge clk);

    // R10: reset asserts asynchronously between edges
    @(posedge clk); #5;
    rst_n = 1'b0;
    #1;
    chk("R10 async reset", 8'h00, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule